// File: doc/BRIEF.md
# Converter Power-Down and Start-Up Sequencer

This block sequences power-down, filter reset and start-up for the two converter paths of a stereo audio codec. Each path has its own active-low power-down request pin. A request is first brought into the system clock domain by a synchronizer. It then has to hold its new level for a minimum number of system clock cycles before it is accepted, so that short glitches are thrown away. While a path is powered down, its digital filters are held in reset.

The DAC path has no start-up delay. When its request is accepted it goes straight back to running. The ADC path works differently. When its request is released it enters an initialization period, during which its serial output data is forced to zero. That period lasts a fixed number of frame-clock rising edges. Only after the period ends is the ADC data flagged valid. Pulling the ADC request low during initialization cancels the count. The next release starts the count again from zero.

Each path reports its state as OFF, INIT or RUN. The enable of a path goes high one cycle before the filter reset of that path is released. On the way down, the enable drops one cycle before the reset is asserted again. A further output tells the rest of the chip when the clocks may be stopped. That output is high only while both paths are powered down.

Top module: `codec_pwr_seq`

## Requirements
- R1: During and after synchronous reset (rst_n low) both states read OFF (encoding OFF=0, INIT=1, RUN=2), both resets are asserted (low), both enables are low, adc_zero=1, adc_valid=0 and clk_stop_ok=1.
- R2: A level change on a power-down pin is accepted only after it has been held for MIN_PW system clock cycles. If the pin changes just before clock edge k, the path enable follows at edge k+MIN_PW+1 and the path state and reset follow at edge k+MIN_PW+2.
- R3: A level change held for fewer than MIN_PW cycles is ignored: the path state, enable and reset do not change.
- R4: While adc_pdn_n is accepted low, adc_state is OFF, adc_rst_n is low and adc_en is low.
- R5: While dac_pdn_n is accepted low, dac_state is OFF and dac_rst_n is low. When it is accepted high, dac_state goes directly to RUN with no initialization, and dac_state never reads INIT.
- R6: When adc_pdn_n is accepted high, adc_state becomes INIT. Throughout INIT, adc_zero=1 and adc_valid=0.
- R7: INIT lasts exactly INIT_FRAMES rising edges of lrck that are counted while in INIT. After the last one, adc_state becomes RUN, adc_valid=1 and adc_zero=0.
- R8: Accepted low on adc_pdn_n during INIT returns adc_state to OFF. The next release requires a full INIT_FRAMES rising edges again.
- R9: The ADC initialization has no effect on the DAC path: dac_state stays RUN while the ADC is in INIT.
- R10: clk_stop_ok is 1 exactly when both adc_state and dac_state are OFF.
- R11: lrck rising edges while the ADC is in RUN are ignored, and adc_state stays RUN.
- R12: A path enable rises one cycle before that path's reset is released, and it falls one cycle before that path's reset is asserted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adc_pdn_n | input | 1 | ADC power-down request, low = power down, asynchronous |
| dac_pdn_n | input | 1 | DAC power-down request, low = power down, asynchronous |
| lrck | input | 1 | Frame clock, sampled in the system clock domain |
| adc_en | output | 1 | ADC path enable (accepted power request) |
| adc_rst_n | output | 1 | ADC digital filter reset, active low |
| adc_zero | output | 1 | Forces ADC serial output data to zero |
| adc_valid | output | 1 | ADC output data valid |
| adc_state | output | 2 | ADC state: 0 OFF, 1 INIT, 2 RUN |
| dac_en | output | 1 | DAC path enable (accepted power request) |
| dac_rst_n | output | 1 | DAC digital filter reset, active low |
| dac_state | output | 2 | DAC state: 0 OFF, 2 RUN |
| clk_stop_ok | output | 1 | Clocks may be stopped |

## Verification
Inputs are driven on the falling clock edge, so the first rising edge that samples a change is known. From that edge, the path enable is due MIN_PW+1 edges later and the state and reset are due MIN_PW+2 edges later. The bench samples one cycle before and one cycle after each of these points to pin down the exact latency. Each lrck rising edge reaches the frame counter three system clock edges after it is driven. Each lrck period in the bench is eight cycles long, so an INIT-to-RUN check placed one full period after the final counted edge falls after the counter has updated. Every other check is taken after a settling wait longer than the filter window.

// File: rtl/codec_pwr_pkg.sv
// Shared types for the converter power sequencer.
package codec_pwr_pkg;
    // Path state as reported on the status outputs.
    typedef enum logic [1:0] {
        PS_OFF  = 2'd0,
        PS_INIT = 2'd1,
        PS_RUN  = 2'd2
    } path_st_t;
endpackage

// File: rtl/pd_filter.sv
// Power-down request filter.
// Brings one asynchronous active-low power-down pin into the clk domain through
// SYNC_STAGES flops, then accepts a new level only after it has stayed for
// MIN_PW consecutive cycles. Assumes SYNC_STAGES >= 2 and MIN_PW >= 1.
// The output level_o is 1 when power is requested.
module pd_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_PW      = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic level_o
);
    localparam int CW = $clog2(MIN_PW + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_PW - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_q;
    logic                   level_q;
    logic                   synced;

    assign synced  = sync_q[SYNC_STAGES-1];
    assign level_o = level_q;

    // Shift the raw pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
    end

    // Count cycles of disagreement and adopt the new level after MIN_PW of them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            run_q   <= '0;
        end else if (synced == level_q) begin
            run_q   <= '0;
        end else if (run_q == LAST) begin
            level_q <= synced;
            run_q   <= '0;
        end else begin
            run_q   <= run_q + 1'b1;
        end
    end

    AST_LEVEL_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_q) |-> level_q == $past(synced)); // R2
    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= LAST); // R3
endmodule

// File: rtl/lrck_edge.sv
// Frame clock rising-edge detector.
// Samples lrck through SYNC_STAGES flops and one history flop, and pulses
// rise_o for one clk cycle per rising edge. Assumes lrck is much slower than clk.
module lrck_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lrck,
    output logic rise_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   hist_q;

    assign rise_o = sync_q[SYNC_STAGES-1] & ~hist_q;

    // Synchronize lrck and keep the previous synchronized value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            hist_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], lrck};
            hist_q <= sync_q[SYNC_STAGES-1];
        end
    end

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R7
endmodule

// File: rtl/adc_init_fsm.sv
// ADC path start-up controller.
// OFF while power is not requested. On acceptance of a release it enters INIT
// and counts INIT_FRAMES frame ticks, then enters RUN. A dropped request in any
// state returns to OFF and clears the count. Assumes INIT_FRAMES >= 1.
module adc_init_fsm
    import codec_pwr_pkg::*;
#(
    parameter int INIT_FRAMES = 2081
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_i,
    input  logic     tick_i,
    output path_st_t state_o
);
    localparam int FW = $clog2(INIT_FRAMES + 1);
    localparam logic [FW-1:0] LAST = FW'(INIT_FRAMES - 1);

    path_st_t      state_q;
    logic [FW-1:0] frm_q;

    assign state_o = state_q;

    // Advance through OFF, INIT and RUN and count frames while initializing.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_i) begin
            state_q <= PS_OFF;
            frm_q   <= '0;
        end else begin
            case (state_q)
                PS_OFF: begin
                    state_q <= PS_INIT;
                    frm_q   <= '0;
                end
                PS_INIT: begin
                    if (tick_i) begin
                        if (frm_q == LAST) begin
                            state_q <= PS_RUN;
                            frm_q   <= '0;
                        end else begin
                            frm_q   <= frm_q + 1'b1;
                        end
                    end
                end
                default: state_q <= PS_RUN;
            endcase
        end
    end

    AST_OFF_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> state_q == PS_OFF); // R4
    AST_ENTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_OFF && req_i) |=> state_q == PS_INIT); // R6
    AST_RUN_VIA_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_RUN && $past(state_q) != PS_RUN) |-> $past(state_q) == PS_INIT); // R7
    AST_RUN_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_RUN && $past(state_q) == PS_INIT) |-> $past(tick_i)); // R7
    AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        frm_q <= LAST); // R8
endmodule

// File: rtl/codec_pwr_seq.sv
// Converter power-down and start-up sequencer, top level.
// Filters both power-down pins, runs the ADC start-up count on frame ticks,
// drives per-path enables, filter resets and status, the ADC zero/valid flags
// and the clock-stop permission. Assumes clk is far faster than lrck.
module codec_pwr_seq
    import codec_pwr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_PW      = 30,
    parameter int INIT_FRAMES = 2081
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adc_pdn_n,
    input  logic       dac_pdn_n,
    input  logic       lrck,
    output logic       adc_en,
    output logic       adc_rst_n,
    output logic       adc_zero,
    output logic       adc_valid,
    output logic [1:0] adc_state,
    output logic       dac_en,
    output logic       dac_rst_n,
    output logic [1:0] dac_state,
    output logic       clk_stop_ok
);
    localparam int NPATH = 2;
    localparam int ADC = 0;
    localparam int DAC = 1;

    logic [NPATH-1:0] pins_n;
    logic [NPATH-1:0] req;
    logic             frame_tick;
    path_st_t         adc_st;
    path_st_t         dac_st_q;

    assign pins_n[ADC] = adc_pdn_n;
    assign pins_n[DAC] = dac_pdn_n;

    // One request filter per converter path.
    for (genvar p = 0; p < NPATH; p++) begin : g_filt
        pd_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .MIN_PW      (MIN_PW)
        ) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_n   (pins_n[p]),
            .level_o (req[p])
        );
    end

    lrck_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lrck   (lrck),
        .rise_o (frame_tick)
    );

    adc_init_fsm #(
        .INIT_FRAMES (INIT_FRAMES)
    ) u_adc (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req[ADC]),
        .tick_i  (frame_tick),
        .state_o (adc_st)
    );

    // DAC path has no start-up period: it follows its accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) dac_st_q <= PS_OFF;
        else        dac_st_q <= req[DAC] ? PS_RUN : PS_OFF;
    end

    assign adc_en      = req[ADC];
    assign dac_en      = req[DAC];
    assign adc_rst_n   = (adc_st != PS_OFF);
    assign dac_rst_n   = (dac_st_q != PS_OFF);
    assign adc_valid   = (adc_st == PS_RUN);
    assign adc_zero    = (adc_st != PS_RUN);
    assign adc_state   = adc_st;
    assign dac_state   = dac_st_q;
    assign clk_stop_ok = (adc_st == PS_OFF) && (dac_st_q == PS_OFF);

    AST_DAC_NO_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        dac_st_q != PS_INIT); // R5
    AST_DAC_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        dac_en |=> dac_st_q == PS_RUN); // R5
    AST_STOP_BOTH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop_ok |-> ($past(!adc_en) && $past(!dac_en))); // R10
    AST_ADC_EN_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_rst_n) |-> $past(adc_en)); // R12
    AST_DAC_EN_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_rst_n) |-> $past(dac_en)); // R12
    AST_ADC_EN_FALLS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_rst_n) |-> $past(!adc_en)); // R12
endmodule

// File: tb/codec_pwr_seq_tb.sv
`timescale 1ns/1ps
module codec_pwr_seq_tb;
    localparam int MIN_PW = 30;
    localparam int FRAMES = 2081;
    localparam int SETTLE = MIN_PW + 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adc_pdn_n = 1'b0, dac_pdn_n = 1'b0, lrck = 1'b0;
    logic adc_en, adc_rst_n, adc_zero, adc_valid, dac_en, dac_rst_n, clk_stop_ok;
    logic [1:0] adc_state, dac_state;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    codec_pwr_seq #(.MIN_PW(MIN_PW), .INIT_FRAMES(FRAMES)) u_dut (
        .clk(clk), .rst_n(rst_n), .adc_pdn_n(adc_pdn_n), .dac_pdn_n(dac_pdn_n),
        .lrck(lrck), .adc_en(adc_en), .adc_rst_n(adc_rst_n), .adc_zero(adc_zero),
        .adc_valid(adc_valid), .adc_state(adc_state), .dac_en(dac_en),
        .dac_rst_n(dac_rst_n), .dac_state(dac_state), .clk_stop_ok(clk_stop_ok)
    );

    // Vector: {adc_pdn_n, dac_pdn_n, exp adc_state, exp dac_state, exp clk_stop_ok}
    localparam logic [6:0] VEC [5] = '{
        7'b0_0_00_00_1, 7'b0_1_00_10_0, 7'b1_1_01_10_0,
        7'b1_0_01_00_0, 7'b0_0_00_00_1
    };

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frames(input int n);
        for (int i = 0; i < n; i++) begin
            lrck = 1'b1; cyc(4);
            lrck = 1'b0; cyc(4);
        end
    endtask

    initial begin
        cyc(4);
        // R1 reset state
        chk("R1 adc_state", adc_state, 0); chk("R1 dac_state", dac_state, 0);
        chk("R1 adc_rst_n", adc_rst_n, 0); chk("R1 dac_rst_n", dac_rst_n, 0);
        chk("R1 adc_zero", adc_zero, 1);   chk("R1 adc_valid", adc_valid, 0);
        chk("R1 clk_stop_ok", clk_stop_ok, 1); chk("R1 adc_en", adc_en, 0);
        rst_n = 1'b1; cyc(2);

        // Table walk: R4 R5 R6 R10
        for (int v = 0; v < 5; v++) begin
            adc_pdn_n = VEC[v][6]; dac_pdn_n = VEC[v][5];
            cyc(SETTLE);
            chk("R4/R6 adc_state", adc_state, VEC[v][4:3]);
            chk("R5 dac_state", dac_state, VEC[v][2:1]);
            chk("R10 clk_stop_ok", clk_stop_ok, VEC[v][0]);
            chk("R4 adc_en", adc_en, VEC[v][6]);
        end

        // R2 exact latency and R12 ordering on the DAC release
        dac_pdn_n = 1'b1;
        cyc(MIN_PW + 1); chk("R2 dac_en early", dac_en, 0);
        cyc(1); chk("R2 dac_en due", dac_en, 1); chk("R12 dac_rst_n held", dac_rst_n, 0);
        cyc(1); chk("R12 dac_rst_n released", dac_rst_n, 1); chk("R5 dac RUN", dac_state, 2);
        // R12 ordering on the DAC power-down
        dac_pdn_n = 1'b0;
        cyc(MIN_PW + 2); chk("R12 dac_en dropped", dac_en, 0); chk("R12 dac_rst_n still", dac_rst_n, 1);
        cyc(1); chk("R12 dac_rst_n asserted", dac_rst_n, 0);
        dac_pdn_n = 1'b1; cyc(SETTLE);

        // R6 R7 R9 R11 ADC start-up
        adc_pdn_n = 1'b1; cyc(SETTLE);
        chk("R6 adc INIT", adc_state, 1); chk("R6 adc_zero", adc_zero, 1);
        chk("R6 adc_valid", adc_valid, 0);
        frames(FRAMES - 1);
        chk("R7 still INIT", adc_state, 1); chk("R9 dac RUN", dac_state, 2);
        frames(1);
        chk("R7 RUN", adc_state, 2); chk("R7 adc_valid", adc_valid, 1);
        chk("R7 adc_zero", adc_zero, 0);
        frames(5);
        chk("R11 stays RUN", adc_state, 2);

        // R3 short pulse ignored
        adc_pdn_n = 1'b0; cyc(MIN_PW - 1); adc_pdn_n = 1'b1;
        cyc(2 * SETTLE);
        chk("R3 short pulse", adc_state, 2); chk("R3 adc_en", adc_en, 1);

        // R2 pulse of exactly MIN_PW accepted
        adc_pdn_n = 1'b0; cyc(MIN_PW); adc_pdn_n = 1'b1;
        cyc(2 * SETTLE);
        chk("R2 min pulse accepted", adc_state, 1);

        // R8 abort during INIT and full restart
        frames(1000);
        adc_pdn_n = 1'b0; cyc(SETTLE);
        chk("R8 abort OFF", adc_state, 0); chk("R8 dac RUN", dac_state, 2);
        adc_pdn_n = 1'b1; cyc(SETTLE);
        frames(1500); chk("R8 restart INIT", adc_state, 1);
        frames(FRAMES - 1501); chk("R8 last-1 INIT", adc_state, 1);
        frames(1); chk("R8 RUN after full", adc_state, 2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule